// File: doc/BRIEF.md
# Sequential Floating-Point Significand Divider

This block divides one unpacked floating-point operand (the dividend) by another (the divisor). Each operand arrives already split into a class code, a sign, a signed unbiased exponent and a significand normalized to [1,2), with the hidden one in the top bit. A single start pulse launches an operation. Operand pairs that involve a zero, an infinity or a NaN are resolved straight from their classes. Two normal operands go through a restoring shift-and-subtract loop that produces one quotient bit per clock.

The quotient leaves the block already normalized. A first trial subtraction of the divisor from the dividend significand decides before the loop begins whether the raw quotient lies below 1.0. If it does, the remainder is doubled up front and the exponent is lowered by one. The loop then produces the significand bits together with two guard and round bits, and the remainder left at the end gives the sticky flag. Rounding, packing and denormals are left to neighbouring logic.

Top module: `fp_sig_div`

## Requirements
- R1: For two normal operands with significand integers X and Y (MANT_W bits, top bit 1), let s = 1 when X < Y and 0 otherwise. The result class is normal, the exponent is ea - eb - s, and res_sig equals floor(X * 2^(QW-1+s) / Y), where QW = MANT_W + 2. Bit QW-1 of res_sig is therefore always 1.
- R2: For two normal operands, res_sticky is 1 exactly when the remainder X * 2^(QW-1+s) mod Y is nonzero.
- R3: For normal/normal, normal/infinity and normal/zero, the result sign is the XOR of the operand signs.
- R4: Class codes are 0 zero, 1 normal, 2 infinity, 3 NaN. If either operand is a NaN, the result is that NaN (sign, exponent, and significand shifted left by two) and flg_invalid is 1. When exactly one operand is a signalling NaN, that operand is returned. Otherwise the dividend is returned if it is a NaN, and the divisor if not.
- R5: Infinity/infinity and zero/zero return the default NaN (class 3, sign 0, exponent 0, only res_sig bit QW-1 set) with flg_invalid 1.
- R6: Infinity divided by a normal or zero, and zero divided by a normal or infinity, return the dividend's class, sign, exponent and significand unchanged, with no flag raised.
- R7: Normal/infinity gives zero (exponent 0, significand 0). Normal/zero gives infinity with flg_divzero 1. Sticky is 0 for every result that is not a divide.
- R8: When start is sampled by the clock edge that accepts it, done rises after that edge for a special case. For a normal divide it rises QW edges later, so QW+1 edges in all including the accepting one. Done lasts one cycle unless a new start is accepted in that cycle.
- R9: Start is ignored while busy is high, and the operation in flight finishes with its own result and timing. A start given in the cycle done is high is accepted.
- R10: Result and flag outputs hold their values after done until the next start is accepted.
- R11: After reset, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| a_cls | input | 2 | Dividend class code |
| a_sign | input | 1 | Dividend sign |
| a_snan | input | 1 | Dividend NaN is signalling |
| a_exp | input | EXP_W | Dividend exponent, signed |
| a_sig | input | MANT_W | Dividend significand |
| b_cls | input | 2 | Divisor class code |
| b_sign | input | 1 | Divisor sign |
| b_snan | input | 1 | Divisor NaN is signalling |
| b_exp | input | EXP_W | Divisor exponent, signed |
| b_sig | input | MANT_W | Divisor significand |
| busy | output | 1 | Divide loop running |
| done | output | 1 | Result valid pulse |
| res_cls | output | 2 | Result class code |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W+1 | Result exponent, signed |
| res_sig | output | QW | Result significand with guard and round |
| res_sticky | output | 1 | Nonzero final remainder |
| flg_invalid | output | 1 | Invalid-operation flag |
| flg_divzero | output | 1 | Divide-by-zero flag |

## Verification
Two things can fall in the same cycle here: the done pulse that closes one operation, and the acceptance of a new start. A start pulse can also land while the loop is still running. The bench runs its operations back to back, driving the next start in the very cycle done is seen, and judges by the latency and the result of the next operation. Separately, it pulses start with different operands halfway through a divide and checks that both the first result and its latency are unchanged.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fcls_e;
endpackage

// File: rtl/fpdiv_special.sv
module fpdiv_special #(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 10,
  localparam int QW    = MANT_W + 2
) (
  input  logic [1:0]        a_cls,
  input  logic              a_sign,
  input  logic              a_snan,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_sig,
  input  logic [1:0]        b_cls,
  input  logic              b_sign,
  input  logic              b_snan,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_sig,
  output logic              is_spec,
  output logic [1:0]        sp_cls,
  output logic              sp_sign,
  output logic [EXP_W:0]    sp_exp,
  output logic [QW-1:0]     sp_sig,
  output logic              sp_inv,
  output logic              sp_dz
);
  import fpdiv_pkg::*;

  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, a_sig_nan, b_sig_nan, take_b;
  logic [EXP_W:0] a_exp_x, b_exp_x;
  logic [QW-1:0]  dflt_sig;

  assign a_nan     = (a_cls == CLS_NAN);
  assign b_nan     = (b_cls == CLS_NAN);
  assign a_inf     = (a_cls == CLS_INF);
  assign b_inf     = (b_cls == CLS_INF);
  assign a_zero    = (a_cls == CLS_ZERO);
  assign b_zero    = (b_cls == CLS_ZERO);
  assign a_sig_nan = a_nan && a_snan;
  assign b_sig_nan = b_nan && b_snan;
  assign take_b    = !a_nan || (b_sig_nan && !a_sig_nan);
  assign a_exp_x   = {a_exp[EXP_W-1], a_exp};
  assign b_exp_x   = {b_exp[EXP_W-1], b_exp};
  assign dflt_sig  = {1'b1, {(QW-1){1'b0}}};

  always_comb begin
    is_spec = 1'b1;
    sp_cls  = a_cls;
    sp_sign = a_sign;
    sp_exp  = a_exp_x;
    sp_sig  = {a_sig, 2'b00};
    sp_inv  = 1'b0;
    sp_dz   = 1'b0;
    if (a_nan || b_nan) begin
      sp_inv = 1'b1;
      if (take_b) begin
        sp_cls  = b_cls;
        sp_sign = b_sign;
        sp_exp  = b_exp_x;
        sp_sig  = {b_sig, 2'b00};
      end
    end else if ((a_inf && b_inf) || (a_zero && b_zero)) begin
      sp_inv  = 1'b1;
      sp_cls  = CLS_NAN;
      sp_sign = 1'b0;
      sp_exp  = '0;
      sp_sig  = dflt_sig;
    end else if (a_inf || a_zero) begin
      // dividend passes through unchanged
    end else if (b_inf) begin
      sp_cls  = CLS_ZERO;
      sp_sign = a_sign ^ b_sign;
      sp_exp  = '0;
      sp_sig  = '0;
    end else if (b_zero) begin
      sp_cls  = CLS_INF;
      sp_sign = a_sign ^ b_sign;
      sp_dz   = 1'b1;
    end else begin
      is_spec = 1'b0;
    end
  end
endmodule

// File: rtl/fpdiv_ctrl.sv
module fpdiv_ctrl #(
  parameter int QW    = 26,
  localparam int CW   = $clog2(QW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_spec,
  output logic accept,
  output logic iter_en,
  output logic last,
  output logic busy,
  output logic done
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  assign accept  = start && (st_q == ST_IDLE);
  assign iter_en = (st_q == ST_RUN);
  assign last    = iter_en && (cnt_q == CW'(1));
  assign busy    = iter_en;
  assign done    = done_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (accept) begin
      if (is_spec) begin
        done_d = 1'b1;
      end else begin
        st_d  = ST_RUN;
        cnt_d = CW'(QW);
      end
    end else if (iter_en) begin
      cnt_d = cnt_q - CW'(1);
      if (last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // R8: the count stays inside its window while the loop runs
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0) && (cnt_q <= CW'(QW)));
  // R8: a done pulse ends unless a new start was accepted in its cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || $past(start)));
endmodule

// File: rtl/fpdiv_core.sv
module fpdiv_core #(
  parameter int MANT_W = 24,
  localparam int QW    = MANT_W + 2,
  localparam int RW    = MANT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              iter_en,
  input  logic [MANT_W-1:0] x_sig,
  input  logic [MANT_W-1:0] y_sig,
  output logic              pre_shift,
  output logic [QW-1:0]     q_nxt,
  output logic              sticky_nxt
);
  logic [RW-1:0]     rem_q, rem_d, rem_kept;
  logic [MANT_W-1:0] div_q, div_d;
  logic [QW-1:0]     quo_q, quo_d;
  logic [RW:0]       first_trial, trial;
  logic              qbit;

  // first trial subtraction: its sign decides the pre-normalization
  assign first_trial = {2'b00, x_sig} - {2'b00, y_sig};
  assign pre_shift   = first_trial[RW];

  // loop step: trial subtract, keep the difference when it does not underflow
  assign trial      = {1'b0, rem_q} - {2'b00, div_q};
  assign qbit       = ~trial[RW];
  assign rem_kept   = qbit ? trial[RW-1:0] : rem_q;
  assign q_nxt      = {quo_q[QW-2:0], qbit};
  assign sticky_nxt = |rem_kept;

  always_comb begin
    rem_d = rem_q;
    div_d = div_q;
    quo_d = quo_q;
    if (load_en) begin
      rem_d = pre_shift ? {x_sig, 1'b0} : {1'b0, x_sig};
      div_d = y_sig;
      quo_d = '0;
    end else if (iter_en) begin
      rem_d = {rem_kept[RW-2:0], 1'b0};
      quo_d = q_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      div_q <= '0;
      quo_q <= '0;
    end else begin
      rem_q <= rem_d;
      div_q <= div_d;
      quo_q <= quo_d;
    end
  end

  // R1: the partial remainder stays below twice the divisor
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    iter_en |-> (rem_q < {div_q, 1'b0}));
  // R9: the captured divisor does not move while the loop runs
  a_r9_div_stable: assert property (@(posedge clk) disable iff (!rst_n)
    iter_en |=> $stable(div_q));
endmodule

// File: rtl/fp_sig_div.sv
module fp_sig_div #(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 10,
  localparam int QW    = MANT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        a_cls,
  input  logic              a_sign,
  input  logic              a_snan,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_sig,
  input  logic [1:0]        b_cls,
  input  logic              b_sign,
  input  logic              b_snan,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_sig,
  output logic              busy,
  output logic              done,
  output logic [1:0]        res_cls,
  output logic              res_sign,
  output logic [EXP_W:0]    res_exp,
  output logic [QW-1:0]     res_sig,
  output logic              res_sticky,
  output logic              flg_invalid,
  output logic              flg_divzero
);
  import fpdiv_pkg::*;

  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic           is_spec, sp_sign, sp_inv, sp_dz;
  logic [1:0]     sp_cls;
  logic [EXP_W:0] sp_exp;
  logic [QW-1:0]  sp_sig;

  fpdiv_special #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_special (
    .a_cls(a_cls), .a_sign(a_sign), .a_snan(a_snan), .a_exp(a_exp), .a_sig(a_sig),
    .b_cls(b_cls), .b_sign(b_sign), .b_snan(b_snan), .b_exp(b_exp), .b_sig(b_sig),
    .is_spec(is_spec), .sp_cls(sp_cls), .sp_sign(sp_sign), .sp_exp(sp_exp),
    .sp_sig(sp_sig), .sp_inv(sp_inv), .sp_dz(sp_dz)
  );

  logic accept, iter_en, last;

  fpdiv_ctrl #(.QW(QW)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .start(start), .is_spec(is_spec),
    .accept(accept), .iter_en(iter_en), .last(last), .busy(busy), .done(done)
  );

  logic          load_div, pre_shift, sticky_nxt;
  logic [QW-1:0] q_nxt;

  assign load_div = accept && !is_spec;

  fpdiv_core #(.MANT_W(MANT_W)) u_core (
    .clk(clk), .rst_n(rst_s), .load_en(load_div), .iter_en(iter_en),
    .x_sig(a_sig), .y_sig(b_sig), .pre_shift(pre_shift),
    .q_nxt(q_nxt), .sticky_nxt(sticky_nxt)
  );

  logic [EXP_W:0] div_exp;
  assign div_exp = {a_exp[EXP_W-1], a_exp} - {b_exp[EXP_W-1], b_exp}
                 - {{EXP_W{1'b0}}, pre_shift};

  logic [1:0]     cls_d;
  logic           sign_d, stk_d, inv_d, dz_d;
  logic [EXP_W:0] exp_d;
  logic [QW-1:0]  sig_d;

  always_comb begin
    cls_d  = res_cls;
    sign_d = res_sign;
    exp_d  = res_exp;
    sig_d  = res_sig;
    stk_d  = res_sticky;
    inv_d  = flg_invalid;
    dz_d   = flg_divzero;
    if (accept && is_spec) begin
      cls_d  = sp_cls;
      sign_d = sp_sign;
      exp_d  = sp_exp;
      sig_d  = sp_sig;
      stk_d  = 1'b0;
      inv_d  = sp_inv;
      dz_d   = sp_dz;
    end else if (load_div) begin
      cls_d  = CLS_NORM;
      sign_d = a_sign ^ b_sign;
      exp_d  = div_exp;
      inv_d  = 1'b0;
      dz_d   = 1'b0;
    end else if (last) begin
      sig_d  = q_nxt;
      stk_d  = sticky_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      res_cls     <= CLS_ZERO;
      res_sign    <= 1'b0;
      res_exp     <= '0;
      res_sig     <= '0;
      res_sticky  <= 1'b0;
      flg_invalid <= 1'b0;
      flg_divzero <= 1'b0;
    end else begin
      res_cls     <= cls_d;
      res_sign    <= sign_d;
      res_exp     <= exp_d;
      res_sig     <= sig_d;
      res_sticky  <= stk_d;
      flg_invalid <= inv_d;
      flg_divzero <= dz_d;
    end
  end

  // R1: a normal result always carries its leading one
  a_r1_norm_lead: assert property (@(posedge clk) disable iff (!rst_s)
    (done && res_cls == CLS_NORM) |-> res_sig[QW-1]);
  // R5: an invalid flag always comes with a NaN result
  a_r5_inv_nan: assert property (@(posedge clk) disable iff (!rst_s)
    (done && flg_invalid) |-> (res_cls == CLS_NAN));
  // R7: divide-by-zero always yields infinity
  a_r7_dz_inf: assert property (@(posedge clk) disable iff (!rst_s)
    (done && flg_divzero) |-> (res_cls == CLS_INF));
  // R9: class, sign and exponent stay fixed while the loop runs
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_s)
    busy |=> ($stable(res_cls) && $stable(res_sign) && $stable(res_exp)));
endmodule

// File: tb/fp_sig_div_bench.sv
module fp_sig_div_bench;
  localparam int MW = 24;
  localparam int EW = 10;
  localparam int QW = MW + 2;
  localparam int NV = 9;

  localparam logic [MW-1:0] TX [NV] = '{24'h800000, 24'hC00000, 24'h800000, 24'hFFFFFF,
    24'h800000, 24'hAAAAAA, 24'h9A3C5F, 24'h9A3C5E, 24'hB504F3};
  localparam logic [MW-1:0] TY [NV] = '{24'h800000, 24'h800000, 24'hC00000, 24'h800000,
    24'hFFFFFF, 24'hE38E39, 24'h9A3C5E, 24'h9A3C5F, 24'h8F1BBD};
  localparam int TEA [NV] = '{3, 0, -5, 100, -200, 1, 0, 0, -1};
  localparam int TEB [NV] = '{1, 0, 7, -100, 300, 2, 0, 0, -1};

  logic clk, rst_n, start;
  logic [1:0] a_cls, b_cls;
  logic a_sign, a_snan, b_sign, b_snan;
  logic [EW-1:0] a_exp, b_exp;
  logic [MW-1:0] a_sig, b_sig;
  logic busy, done, res_sign, res_sticky, flg_invalid, flg_divzero;
  logic [1:0] res_cls;
  logic [EW:0] res_exp;
  logic [QW-1:0] res_sig;

  fp_sig_div u_fp_sig_div (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_cls(a_cls), .a_sign(a_sign), .a_snan(a_snan), .a_exp(a_exp), .a_sig(a_sig),
    .b_cls(b_cls), .b_sign(b_sign), .b_snan(b_snan), .b_exp(b_exp), .b_sig(b_sig),
    .busy(busy), .done(done), .res_cls(res_cls), .res_sign(res_sign),
    .res_exp(res_exp), .res_sig(res_sig), .res_sticky(res_sticky),
    .flg_invalid(flg_invalid), .flg_divzero(flg_divzero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int lat;

  task automatic check(input string tag, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic set_ops(input logic [1:0] ac, input logic as, input logic an, input int ae,
                         input logic [MW-1:0] asg, input logic [1:0] bc, input logic bs,
                         input logic bn, input int be, input logic [MW-1:0] bsg);
    a_cls = ac; a_sign = as; a_snan = an; a_exp = EW'(ae); a_sig = asg;
    b_cls = bc; b_sign = bs; b_snan = bn; b_exp = EW'(be); b_sig = bsg;
  endtask

  // called at a negedge; returns at the negedge where done is high (or on timeout)
  task automatic launch(input int poke_at);
    start = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 100) begin
      if (lat == poke_at) begin
        start = 1'b1;
        a_sig = 24'hFFFFFF; b_sig = 24'h800001; a_exp = '0; a_sign = ~a_sign;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic check_res(input string tag, input int ecls, input int esign, input int eexp,
                           input longint esig, input int estk, input int einv, input int edz);
    check({tag, " cls"}, longint'(res_cls), longint'(ecls));
    check({tag, " sign"}, longint'(res_sign), longint'(esign));
    check({tag, " exp"}, longint'($signed(res_exp)), longint'(eexp));
    check({tag, " sig"}, longint'(res_sig), esig);
    check({tag, " sticky"}, longint'(res_sticky), longint'(estk));
    check({tag, " invalid"}, longint'(flg_invalid), longint'(einv));
    check({tag, " divzero"}, longint'(flg_divzero), longint'(edz));
  endtask

  task automatic ref_div(input logic [MW-1:0] x, input logic [MW-1:0] y, input int ea,
                         input int eb, output longint q, output int stk, output int e);
    longint unsigned num;
    int s;
    s = (x < y) ? 1 : 0;
    num = longint'(x) << (QW - 1 + s);
    q = longint'(num / longint'(y));
    stk = ((num % longint'(y)) != 0) ? 1 : 0;
    e = ea - eb - s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint q, saved_sig;
    int stk, e;
    longint dnan;
    dnan = longint'(1) << (QW - 1);
    rst_n = 1'b0; start = 1'b0;
    set_ops(2'd1, 1'b0, 1'b0, 0, 24'h800000, 2'd1, 1'b0, 1'b0, 0, 24'h800000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 busy", longint'(busy), 0);
    check("R11 done", longint'(done), 0);

    // table of normal divides, run back to back (R9: start given in the done cycle)
    for (int i = 0; i < NV; i++) begin
      set_ops(2'd1, i[0], 1'b0, TEA[i], TX[i], 2'd1, i[1], 1'b0, TEB[i], TY[i]);
      ref_div(TX[i], TY[i], TEA[i], TEB[i], q, stk, e);
      launch(0);
      check("R8/R9 normal latency", longint'(lat), longint'(QW + 1));
      check_res("R1/R2/R3 divide", 1, int'(i[0] ^ i[1]), e, q, stk, 0, 0);
    end

    // R8: done is a one-cycle pulse; R10: outputs hold
    saved_sig = longint'(res_sig);
    @(negedge clk);
    check("R8 done drop", longint'(done), 0);
    repeat (5) @(negedge clk);
    check("R10 hold sig", longint'(res_sig), saved_sig);

    // R9: start during busy is ignored
    set_ops(2'd1, 1'b1, 1'b0, 4, 24'hAAAAAA, 2'd1, 1'b0, 1'b0, 2, 24'h800000);
    ref_div(24'hAAAAAA, 24'h800000, 4, 2, q, stk, e);
    launch(7);
    check("R9 poke latency", longint'(lat), longint'(QW + 1));
    check_res("R9 poke result", 1, 1, e, q, stk, 0, 0);

    // R4: NaN selection
    set_ops(2'd3, 1'b1, 1'b1, 5, 24'hC00001, 2'd3, 1'b0, 1'b0, 6, 24'hC00002);
    launch(0);
    check("R8 special latency", longint'(lat), 1);
    check_res("R4 snan dividend", 3, 1, 5, longint'(24'hC00001) << 2, 0, 1, 0);
    set_ops(2'd3, 1'b1, 1'b0, 5, 24'hC00001, 2'd3, 1'b0, 1'b1, 6, 24'hC00002);
    launch(0);
    check_res("R4 snan divisor", 3, 0, 6, longint'(24'hC00002) << 2, 0, 1, 0);
    set_ops(2'd3, 1'b1, 1'b0, 5, 24'hC00001, 2'd3, 1'b0, 1'b0, 6, 24'hC00002);
    launch(0);
    check_res("R4 both quiet", 3, 1, 5, longint'(24'hC00001) << 2, 0, 1, 0);
    set_ops(2'd1, 1'b1, 1'b0, 5, 24'h900000, 2'd3, 1'b1, 1'b0, -6, 24'hC00003);
    launch(0);
    check_res("R4 divisor nan", 3, 1, -6, longint'(24'hC00003) << 2, 0, 1, 0);

    // R5: default NaN
    set_ops(2'd2, 1'b1, 1'b0, 9, 24'h800000, 2'd2, 1'b0, 1'b0, 9, 24'h800000);
    launch(0);
    check_res("R5 inf/inf", 3, 0, 0, dnan, 0, 1, 0);
    set_ops(2'd0, 1'b0, 1'b0, 3, 24'h000000, 2'd0, 1'b1, 1'b0, 3, 24'h000000);
    launch(0);
    check_res("R5 zero/zero", 3, 0, 0, dnan, 0, 1, 0);

    // R6: dividend returned unchanged
    set_ops(2'd2, 1'b1, 1'b0, 11, 24'h800000, 2'd1, 1'b0, 1'b0, 2, 24'hA00000);
    launch(0);
    check_res("R6 inf/norm", 2, 1, 11, longint'(24'h800000) << 2, 0, 0, 0);
    set_ops(2'd2, 1'b0, 1'b0, 12, 24'h800000, 2'd0, 1'b1, 1'b0, 0, 24'h000000);
    launch(0);
    check_res("R6 inf/zero", 2, 0, 12, longint'(24'h800000) << 2, 0, 0, 0);
    set_ops(2'd0, 1'b1, 1'b0, -7, 24'h000000, 2'd1, 1'b0, 1'b0, 2, 24'hA00000);
    launch(0);
    check_res("R6 zero/norm", 0, 1, -7, 0, 0, 0, 0);
    set_ops(2'd0, 1'b0, 1'b0, 2, 24'h000000, 2'd2, 1'b1, 1'b0, 0, 24'h800000);
    launch(0);
    check_res("R6 zero/inf", 0, 0, 2, 0, 0, 0, 0);

    // R7 with R3 sign rule
    set_ops(2'd1, 1'b1, 1'b0, 5, 24'hB00000, 2'd2, 1'b0, 1'b0, 0, 24'h800000);
    launch(0);
    check_res("R7/R3 norm/inf", 0, 1, 0, 0, 0, 0, 0);
    set_ops(2'd1, 1'b1, 1'b0, 5, 24'hB00000, 2'd0, 1'b1, 1'b0, -3, 24'h000000);
    launch(0);
    check_res("R7/R3 norm/zero", 2, 0, 5, longint'(24'hB00000) << 2, 0, 0, 1);

    @(negedge clk);
    check("R8 done drop after special", longint'(done), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule